// File: doc/BRIEF.md
# Conditional Block State Tracker

This block holds the 8-bit execution state of a compact instruction set's if-then construct, in which one short prefix instruction makes up to four of the instructions after it conditional. The upper nibble of the state is the condition in force and the lower nibble is a mask that counts down the remaining conditional slots. The block watches decoded halfwords for the prefix, keeps the prefix's low byte as a pending state, and moves that pending state into the live state when the prefix retires. Each later retirement then steps the state forward until the mask empties.

Around exceptions the block splits the state into a 6-bit and a 2-bit field for a saved status word. It captures those fields and zeroes the live state on exception entry, and it rebuilds the state from the two fields on exception return. It also scores the current condition against the N, Z, C and V flags, so that the pipeline can squash an instruction whose condition fails.

The halfword input is a plain strobe with no back-pressure: every halfword presented with its valid bit high is examined in that cycle, and there is no ready signal. All other pins are plain control and status.

Top module: `cond_block_tracker`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the live state, the pending state and the saved fields to zero; with the state at zero, pass_o is 1.
- R2: A halfword is taken as a prefix only when hw_valid_i is 1, hw_i[15:8] equals 0xBF and hw_i[3:0] is nonzero; its low byte then becomes the pending state. The live state does not change until an advance. Any other halfword leaves the pending state unchanged.
- R3: On an advance with a nonzero pending state, the live state is loaded from the pending state and the pending state is cleared. No stepping happens in that cycle.
- R4: On an advance with a zero pending state, the state steps. The 4-bit mask is shifted left by one into 5 bits, bit 4 of the result replaces bit 0 of the condition, and the mask keeps the low 4 bits.
- R5: When a step leaves the mask at zero, the condition also becomes zero. active_o is 1 exactly when state_o[3:0] is nonzero, and cond_o equals state_o[7:4].
- R6: An advance with both the live and the pending state at zero leaves the live state at zero.
- R7: Exception entry (exc_entry_i) copies state[7:2] into save_hi_o and state[1:0] into save_lo_o. It zeroes the live and pending state and discards any prefix captured in the same cycle. It outranks restore and advance.
- R8: Restore (restore_i) sets the state to ({restore_hi_i,2'b00} & 0xFC) | (restore_lo_i & 0x3). It clears the pending state, discards a same-cycle prefix, and outranks advance.
- R9: pass_o is 1 when the block is inactive. Otherwise it follows the condition code, with flags_i[3]=N, [2]=Z, [1]=C, [0]=V: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always 1.
- R10: When a prefix is captured in the same cycle as an advance, the advance uses the pending state held before that edge, and the new prefix byte becomes the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance_i | input | 1 | One pulse per retired instruction |
| hw_valid_i | input | 1 | Decoded halfword present |
| hw_i | input | 16 | Decoded halfword |
| restore_i | input | 1 | Exception return: reload state from the saved fields |
| restore_hi_i | input | 6 | Saved upper field (state bits 7:2) |
| restore_lo_i | input | 2 | Saved lower field (state bits 1:0) |
| exc_entry_i | input | 1 | Exception entry: save and zero the state |
| flags_i | input | 4 | N, Z, C, V from bit 3 down to bit 0 |
| state_o | output | 8 | Live state: condition in bits 7:4, mask in bits 3:0 |
| active_o | output | 1 | Inside a conditional block |
| cond_o | output | 4 | Active condition |
| pass_o | output | 1 | Condition holds, or the block is inactive |
| save_hi_o | output | 6 | Saved upper field from the last exception entry |
| save_lo_o | output | 2 | Saved lower field from the last exception entry |

## Verification
The hardest cases to reach are those where the pending register matters but cannot be seen. The pending state never appears on a port, and a prefix captured together with an advance, exception entry or restore must be kept or dropped by the priority rules. The stimulus therefore presents prefix halfwords in those same cycles and follows each one with bare advances, so that a lost or wrongly kept pending byte shows up in state_o. The sixteen condition codes are reached by restoring states directly, with each code placed in the condition nibble and a nonzero mask, and each is scored against all sixteen flag patterns.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int COND_W = 4;
  localparam int MASK_W = 4;
  localparam int ST_W   = COND_W + MASK_W;
  localparam int LO_W   = 2;
  localparam int HI_W   = ST_W - LO_W;
  localparam int HW_W   = 16;
  localparam logic [7:0] PREFIX_TAG = 8'hBF;

  typedef struct packed {
    logic [COND_W-1:0] cond;
    logic [MASK_W-1:0] mask;
  } blk_state_t;
endpackage

// File: rtl/cbt_prefix_detect.sv
module cbt_prefix_detect
  import cbt_pkg::*;
#(
  parameter int W = HW_W
) (
  input  logic         hw_valid_i,
  input  logic [W-1:0] hw_i,
  output logic         hit_o,
  output blk_state_t   byte_o
);
  localparam int TAG_LSB = W - 8;

  always_comb begin
    hit_o  = hw_valid_i && (hw_i[W-1:TAG_LSB] == PREFIX_TAG) && (hw_i[MASK_W-1:0] != '0);
    byte_o = blk_state_t'(hw_i[ST_W-1:0]);
  end
endmodule

// File: rtl/cbt_step.sv
module cbt_step
  import cbt_pkg::*;
(
  input  blk_state_t cur_i,
  output blk_state_t nxt_o
);
  logic [MASK_W:0] wide;

  always_comb begin
    wide = {cur_i.mask, 1'b0};
    nxt_o.mask = wide[MASK_W-1:0];
    if (wide[MASK_W-1:0] == '0)
      nxt_o.cond = '0;
    else
      nxt_o.cond = {cur_i.cond[COND_W-1:1], wide[MASK_W]};
  end
endmodule

// File: rtl/cbt_cond_eval.sv
module cbt_cond_eval
  import cbt_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [3:0]        flags_i,
  output logic              ok_o
);
  logic n, z, c, v, base;

  always_comb begin
    n = flags_i[3];
    z = flags_i[2];
    c = flags_i[1];
    v = flags_i[0];
    // the lowest code bit inverts the sense of codes 0..13
    unique case (cond_i[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    if (cond_i[3:1] == 3'd7)
      ok_o = 1'b1;
    else
      ok_o = base ^ cond_i[0];
  end
endmodule

// File: rtl/cond_block_tracker.sv
module cond_block_tracker
  import cbt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            advance_i,
  input  logic            hw_valid_i,
  input  logic [HW_W-1:0] hw_i,
  input  logic            restore_i,
  input  logic [HI_W-1:0] restore_hi_i,
  input  logic [LO_W-1:0] restore_lo_i,
  input  logic            exc_entry_i,
  input  logic [3:0]      flags_i,
  output logic [ST_W-1:0] state_o,
  output logic            active_o,
  output logic [COND_W-1:0] cond_o,
  output logic            pass_o,
  output logic [HI_W-1:0] save_hi_o,
  output logic [LO_W-1:0] save_lo_o
);
  blk_state_t cur_q, pend_q, stepped, cap_byte, rebuilt;
  logic       cap_hit, cond_ok;
  logic [ST_W-1:0] save_q;

  cbt_prefix_detect #(.W(HW_W)) u_detect (
    .hw_valid_i (hw_valid_i),
    .hw_i       (hw_i),
    .hit_o      (cap_hit),
    .byte_o     (cap_byte)
  );

  cbt_step u_step (
    .cur_i (cur_q),
    .nxt_o (stepped)
  );

  cbt_cond_eval u_eval (
    .cond_i  (cur_q.cond),
    .flags_i (flags_i),
    .ok_o    (cond_ok)
  );

  always_comb begin
    rebuilt = blk_state_t'((({restore_hi_i, {LO_W{1'b0}}}) & 8'hFC) |
                           ({{HI_W{1'b0}}, restore_lo_i} & 8'h03));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      pend_q <= '0;
      save_q <= '0;
    end else if (exc_entry_i) begin
      save_q <= cur_q;
      cur_q  <= '0;
      pend_q <= '0;
    end else if (restore_i) begin
      cur_q  <= rebuilt;
      pend_q <= '0;
    end else begin
      if (advance_i) begin
        if (pend_q != '0) cur_q <= pend_q;
        else              cur_q <= stepped;
      end
      if (cap_hit)
        pend_q <= cap_byte;
      else if (advance_i && pend_q != '0)
        pend_q <= '0;
    end
  end

  assign state_o   = cur_q;
  assign cond_o    = cur_q.cond;
  assign active_o  = (cur_q.mask != '0);
  assign pass_o    = !active_o || cond_ok;
  assign save_hi_o = save_q[ST_W-1:LO_W];
  assign save_lo_o = save_q[LO_W-1:0];

  // R1: after reset everything is zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (state_o == '0 && save_hi_o == '0 && save_lo_o == '0));

  // R3: pending load wins over stepping
  assert_pending_load_R3: assert property (@(posedge clk) disable iff (rst)
    (advance_i && !exc_entry_i && !restore_i && pend_q != '0) |=> state_o == $past(pend_q));

  // R4: a step shifts the mask by one place
  assert_step_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (advance_i && !exc_entry_i && !restore_i && pend_q == '0) |=>
      state_o[MASK_W-1:0] == {$past(state_o[MASK_W-2:0]), 1'b0});

  // R5: an emptied mask leaves the whole state at zero
  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o[MASK_W-1:0] == '0) |-> (state_o == '0 || $past(restore_i)));

  // R7: exception entry saves and zeroes
  assert_entry_save_R7: assert property (@(posedge clk) disable iff (rst)
    exc_entry_i |=> (state_o == '0 && {save_hi_o, save_lo_o} == $past(state_o)));

  // R8: restore rebuilds from the two fields
  assert_restore_load_R8: assert property (@(posedge clk) disable iff (rst)
    (restore_i && !exc_entry_i) |=> state_o == {$past(restore_hi_i), $past(restore_lo_i)});
endmodule

// File: tb/cond_block_tracker_bench.sv
module cond_block_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  typedef struct packed {
    logic        adv;
    logic        hv;
    logic [15:0] hw;
    logic        rs;
    logic [5:0]  hi;
    logic [1:0]  lo;
    logic        clr;
    logic [3:0]  fl;
    logic [7:0]  est;
    logic        ep;
    logic [7:0]  esv;
    logic [3:0]  req;
  } vec_t;

  // fields: adv, hv, hw, rs, hi, lo, clr, flags, exp state, exp pass, exp save, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,16'hBF18,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd2},  // R2 capture, no change
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h18,1'b1,8'h00,4'd3},  // R3 load
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd5},  // R5 empty
    '{1'b0,1'b1,16'hBF04,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd2},  // R2
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h4,8'h04,1'b1,8'h00,4'd3},  // R3
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h08,1'b0,8'h00,4'd4},  // R4 step
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd5},  // R5
    '{1'b1,1'b1,16'hBFA7,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd10}, // R10 advance from zero plus capture
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h8,8'hA7,1'b0,8'h00,4'd3},  // R3
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h9,8'hAE,1'b1,8'h00,4'd4},  // R4
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h9,8'hBC,1'b0,8'h00,4'd4},  // R4 cond lsb set
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h8,8'hB8,1'b1,8'h00,4'd4},  // R4
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd5},  // R5
    '{1'b0,1'b1,16'hBF30,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd2},  // R2 zero mask ignored
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd2},  // R2
    '{1'b0,1'b1,16'hBE38,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd2},  // R2 wrong tag ignored
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd6},  // R6
    '{1'b0,1'b0,16'hBF38,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd2},  // R2 not valid ignored
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd6},  // R6
    '{1'b1,1'b0,16'h0000,1'b1,6'h23,2'd1,1'b0,4'h2,8'h8D,1'b1,8'h00,4'd8},  // R8 restore beats advance
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b1,4'h2,8'h00,1'b1,8'h8D,4'd7},  // R7 save and zero
    '{1'b0,1'b1,16'hBF18,1'b0,6'h00,2'd0,1'b1,4'h0,8'h00,1'b1,8'h00,4'd7},  // R7 capture discarded
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd7},  // R7
    '{1'b0,1'b1,16'hBF18,1'b1,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd8},  // R8 capture discarded
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd8},  // R8
    '{1'b0,1'b1,16'hBF28,1'b0,6'h00,2'd0,1'b0,4'h0,8'h00,1'b1,8'h00,4'd2},  // R2
    '{1'b1,1'b1,16'hBF64,1'b0,6'h00,2'd0,1'b0,4'h2,8'h28,1'b1,8'h00,4'd10}, // R10 old pending used
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h0,8'h64,1'b0,8'h00,4'd10}, // R10 new pending kept
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h1,8'h68,1'b1,8'h00,4'd4},  // R4
    '{1'b1,1'b0,16'h0000,1'b0,6'h00,2'd0,1'b0,4'h1,8'h00,1'b1,8'h00,4'd5}   // R5
  };

  logic clk = 1'b0;
  logic rst;
  logic advance_i, hw_valid_i, restore_i, exc_entry_i;
  logic [15:0] hw_i;
  logic [5:0] restore_hi_i, save_hi_o;
  logic [1:0] restore_lo_i, save_lo_o;
  logic [3:0] flags_i, cond_o;
  logic [7:0] state_o;
  logic active_o, pass_o;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_block_tracker u_cond_block_tracker (
    .clk, .rst, .advance_i, .hw_valid_i, .hw_i, .restore_i, .restore_hi_i,
    .restore_lo_i, .exc_entry_i, .flags_i, .state_o, .active_o, .cond_o,
    .pass_o, .save_hi_o, .save_lo_o
  );

  function automatic logic exp_cond(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    advance_i = 0; hw_valid_i = 0; hw_i = '0; restore_i = 0;
    restore_hi_i = '0; restore_lo_i = '0; exc_entry_i = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    flags_i = 4'h0;
    rst = 1;
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    chk("R1 state", state_o, 8'h00);
    chk("R1 save", {save_hi_o, save_lo_o}, 8'h00);
    chk("R1 pass", pass_o, 1'b1);
    chk("R1 active", active_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      advance_i = VEC[i].adv; hw_valid_i = VEC[i].hv; hw_i = VEC[i].hw;
      restore_i = VEC[i].rs; restore_hi_i = VEC[i].hi; restore_lo_i = VEC[i].lo;
      exc_entry_i = VEC[i].clr; flags_i = VEC[i].fl;
      tick();
      idle();
      chk($sformatf("R%0d row %0d state", VEC[i].req, i), state_o, VEC[i].est);
      chk($sformatf("R%0d row %0d pass", VEC[i].req, i), pass_o, VEC[i].ep);
      chk($sformatf("R%0d row %0d save", VEC[i].req, i), {save_hi_o, save_lo_o}, VEC[i].esv);
      // R5 derived outputs
      chk($sformatf("R5 row %0d active", i), active_o, VEC[i].est[3:0] != 4'h0);
      chk($sformatf("R5 row %0d cond", i), cond_o, VEC[i].est[7:4]);
    end

    // R9 every code against every flag pattern
    for (int cc = 0; cc < 16; cc++) begin
      restore_i = 1; restore_hi_i = {cc[3:0], 2'b10}; restore_lo_i = 2'b00;
      tick();
      idle();
      for (int f = 0; f < 16; f++) begin
        flags_i = f[3:0];
        #1;
        chk($sformatf("R9 code %0d flags %0h", cc, f), pass_o, exp_cond(cc[3:0], f[3:0]));
      end
    end

    // R7 exception entry outranks restore
    exc_entry_i = 1; restore_i = 1; restore_hi_i = 6'h3F; restore_lo_i = 2'd3;
    tick();
    idle();
    chk("R7 entry beats restore", state_o, 8'h00);
    chk("R7 saved value", {save_hi_o, save_lo_o}, 8'hF8);

    // R1 reset in the middle of a block
    restore_i = 1; restore_hi_i = 6'h15; restore_lo_i = 2'd2;
    tick();
    idle();
    chk("R8 restore value", state_o, 8'h56);
    hw_valid_i = 1; hw_i = 16'hBF42;
    tick();
    idle();
    rst = 1;
    tick();
    rst = 0;
    chk("R1 mid reset state", state_o, 8'h00);
    chk("R1 mid reset save", {save_hi_o, save_lo_o}, 8'h00);
    advance_i = 1;
    tick();
    idle();
    chk("R1 pending cleared by reset", state_o, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule